// File: doc/BRIEF.md
# Programmable Serial Character Receiver

This block recovers characters from an asynchronous serial line. A frame opens with a low start bit and carries 5 to 8 data bits, least significant bit first. An optional parity bit follows, and then one or two high stop bits. Software sets the frame shape through static configuration inputs. Timing comes from a one-cycle tick input that pulses sixteen times per bit period. The block makes no baud rate of its own.

The serial line first passes through a synchroniser. The receiver waits for a falling edge on the line. Half a bit later it checks that the line is still low, and from then on it samples each bit at its centre. A finished character goes into a holding register together with a ready flag. Sticky parity, framing and overrun flags record the errors seen since software last read status. A read strobe for the data and a read strobe for the status let the host clear these flags. An optional level interrupt follows the ready flag.

Top module: `serial_char_receiver`

## Requirements
- R1: `cfg_len` selects the character length: code 0 means 5 bits, 1 means 6, 2 means 7 and 3 means 8. Bits arrive least significant first. `rx_char` holds the character with every unused upper bit at zero.
- R2: A falling edge starts a frame only if the line is still low at the 8th tick after the edge. A low pulse shorter than half a bit returns the receiver to idle and produces no character.
- R3: `data_ready` goes to 1 when a character completes. A one-cycle `rd_data` pulse clears it, unless another character completes in that same cycle.
- R4: `err_frame` goes to 1 when any expected stop bit is sampled low.
- R5: `err_overrun` goes to 1 when a character completes while `data_ready` is 1 and no `rd_data` arrives in that cycle. `rx_char` then holds the newer character.
- R6: When `cfg_par_en` is 1, one parity bit follows the data. `cfg_par_kind` selects the check: 0 even (the data ones plus the parity bit give an even count), 1 odd, 2 the bit must be 0, 3 the bit must be 1. A mismatch sets `err_parity`. When `cfg_par_en` is 0, no parity bit is expected and `err_parity` stays 0.
- R7: A one-cycle `rd_status` pulse clears `err_parity`, `err_frame` and `err_overrun`, unless a character that completes in that same cycle sets a flag again.
- R8: `irq` is 1 exactly while `cfg_irq_en` is 1 and `data_ready` is 1.
- R9: When `cfg_two_stop` is 1, the receiver samples two stop bits before the character completes. When it is 0, it samples one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Oversampling tick, sixteen pulses per bit |
| rx_serial | input | 1 | Asynchronous serial input, idles high |
| cfg_len | input | 2 | Character length code (5 + code bits) |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_kind | input | 2 | Parity check kind: even, odd, zero, one |
| cfg_two_stop | input | 1 | Two stop bits when 1 |
| cfg_irq_en | input | 1 | Receive interrupt enable |
| rd_data | input | 1 | Read strobe for the character register |
| rd_status | input | 1 | Read strobe for the error flags |
| rx_char | output | 8 | Last received character |
| data_ready | output | 1 | Unread character present |
| err_parity | output | 1 | Sticky parity error |
| err_frame | output | 1 | Sticky framing error |
| err_overrun | output | 1 | Sticky overrun error |
| irq | output | 1 | Receive interrupt, level |

## Verification
Two situations are hard to reach from the ports. One is a false start, where the line dips low and rises again before the half-bit confirmation. The bench reaches it by driving a low pulse of two ticks and then checking that no character appears. The other is an overrun, which needs a second full frame to complete while the first is still unread. The bench sends two frames back to back without a read strobe in between. Every combination of length, parity mode and stop count is swept with several data patterns. Corrupted parity and stop bits are injected separately.

// File: rtl/srx_pkg.sv
package srx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP
   } srx_state_e;

   typedef enum logic [1:0] {
      PK_EVEN = 2'd0,
      PK_ODD  = 2'd1,
      PK_ZERO = 2'd2,
      PK_ONE  = 2'd3
   } srx_par_kind_e;

   // expected parity bit for a given data-ones parity and check kind
   function automatic logic par_expect(input logic [1:0] kind, input logic ones_odd);
      case (kind)
         PK_EVEN: par_expect = ones_odd;
         PK_ODD:  par_expect = ~ones_odd;
         PK_ZERO: par_expect = 1'b0;
         default: par_expect = 1'b1;
      endcase
   endfunction

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);

   if (STAGES < 2) begin : g_bad_stages
      $error("srx_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain_q[s] <= RESET_VAL;
         end else if (s == 0) begin
            chain_q[s] <= d_async;
         end else begin
            chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/srx_frame.sv
module srx_frame
   import srx_pkg::*;
#(
   parameter int OVS_RATE = 16,
   parameter int MIN_BITS = 5,
   parameter int MAX_BITS = 8,
   localparam int LENW    = $clog2(MAX_BITS - MIN_BITS + 1),
   localparam int IDXW    = $clog2(MAX_BITS),
   localparam int CNTW    = $clog2(OVS_RATE),
   localparam int HALF    = OVS_RATE / 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick,
   input  logic                line,
   input  logic [LENW-1:0]     cfg_len,
   input  logic                cfg_par_en,
   input  logic [1:0]          cfg_par_kind,
   input  logic                cfg_two_stop,
   output logic                done_o,
   output logic [MAX_BITS-1:0] char_o,
   output logic                perr_o,
   output logic                ferr_o
);

   if (OVS_RATE < 4 || (OVS_RATE % 2) != 0) begin : g_bad_ovs
      $error("srx_frame: OVS_RATE must be even and at least 4");
   end
   if (MIN_BITS < 1 || MAX_BITS <= MIN_BITS) begin : g_bad_len
      $error("srx_frame: MAX_BITS must exceed MIN_BITS");
   end

   srx_state_e          state;
   logic [CNTW-1:0]     tcnt;
   logic [IDXW-1:0]     bidx;
   logic [IDXW-1:0]     last_idx;
   logic [MAX_BITS-1:0] shreg;
   logic                ones_odd;
   logic                perr_q;
   logic                ferr_q;
   logic                stop2_q;
   logic                line_d;
   logic                fall;
   logic                centre;

   assign fall     = line_d & ~line;
   assign centre   = tick && (tcnt == CNTW'(OVS_RATE - 1));
   assign last_idx = IDXW'(MIN_BITS - 1) + IDXW'(cfg_len);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_d <= 1'b1;
      end else begin
         line_d <= line;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         tcnt     <= '0;
         bidx     <= '0;
         shreg    <= '0;
         ones_odd <= 1'b0;
         perr_q   <= 1'b0;
         ferr_q   <= 1'b0;
         stop2_q  <= 1'b0;
         done_o   <= 1'b0;
      end else begin
         done_o <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (fall) begin
                  state    <= ST_START;
                  tcnt     <= '0;
                  bidx     <= '0;
                  shreg    <= '0;
                  ones_odd <= 1'b0;
                  perr_q   <= 1'b0;
                  ferr_q   <= 1'b0;
                  stop2_q  <= 1'b0;
               end
            end
            ST_START: begin
               if (tick) begin
                  if (tcnt == CNTW'(HALF - 1)) begin
                     tcnt  <= '0;
                     state <= line ? ST_IDLE : ST_DATA;
                  end else begin
                     tcnt <= tcnt + 1'b1;
                  end
               end
            end
            ST_DATA: begin
               if (tick) tcnt <= tcnt + 1'b1;
               if (centre) begin
                  tcnt        <= '0;
                  shreg[bidx] <= line;
                  ones_odd    <= ones_odd ^ line;
                  bidx        <= bidx + 1'b1;
                  if (bidx == last_idx) begin
                     state <= cfg_par_en ? ST_PAR : ST_STOP;
                  end
               end
            end
            ST_PAR: begin
               if (tick) tcnt <= tcnt + 1'b1;
               if (centre) begin
                  tcnt   <= '0;
                  perr_q <= (line != par_expect(cfg_par_kind, ones_odd));
                  state  <= ST_STOP;
               end
            end
            ST_STOP: begin
               if (tick) tcnt <= tcnt + 1'b1;
               if (centre) begin
                  tcnt <= '0;
                  if (!line) ferr_q <= 1'b1;
                  if (cfg_two_stop && !stop2_q) begin
                     stop2_q <= 1'b1;
                  end else begin
                     done_o <= 1'b1;
                     state  <= ST_IDLE;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign char_o = shreg;
   assign perr_o = perr_q;
   assign ferr_o = ferr_q;

   assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_start_confirm_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state) == ST_START && state == ST_DATA) |-> !$past(line));

   assert_no_parity_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !cfg_par_en) |-> !perr_o);

endmodule

// File: rtl/srx_hold.sv
module srx_hold #(
   parameter int MAX_BITS = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                done_i,
   input  logic [MAX_BITS-1:0] char_i,
   input  logic                perr_i,
   input  logic                ferr_i,
   input  logic                rd_data,
   input  logic                rd_status,
   input  logic                cfg_irq_en,
   output logic [MAX_BITS-1:0] rx_char,
   output logic                data_ready,
   output logic                err_parity,
   output logic                err_frame,
   output logic                err_overrun,
   output logic                irq
);

   logic ovr_hit;

   assign ovr_hit = done_i && data_ready && !rd_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_char    <= '0;
         data_ready <= 1'b0;
      end else if (done_i) begin
         rx_char    <= char_i;
         data_ready <= 1'b1;
      end else if (rd_data) begin
         data_ready <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_parity  <= 1'b0;
         err_frame   <= 1'b0;
         err_overrun <= 1'b0;
      end else begin
         if (done_i && perr_i)  err_parity  <= 1'b1;
         else if (rd_status)    err_parity  <= 1'b0;
         if (done_i && ferr_i)  err_frame   <= 1'b1;
         else if (rd_status)    err_frame   <= 1'b0;
         if (ovr_hit)           err_overrun <= 1'b1;
         else if (rd_status)    err_overrun <= 1'b0;
      end
   end

   assign irq = cfg_irq_en & data_ready;

   assert_overrun_needs_unread_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_overrun) |-> $past(data_ready));

   assert_read_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data && !done_i) |=> !data_ready);

   assert_status_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_status && !done_i) |=> !(err_parity || err_frame || err_overrun));

endmodule

// File: rtl/serial_char_receiver.sv
module serial_char_receiver #(
   parameter int OVS_RATE    = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick16,
   input  logic       rx_serial,
   input  logic [1:0] cfg_len,
   input  logic       cfg_par_en,
   input  logic [1:0] cfg_par_kind,
   input  logic       cfg_two_stop,
   input  logic       cfg_irq_en,
   input  logic       rd_data,
   input  logic       rd_status,
   output logic [7:0] rx_char,
   output logic       data_ready,
   output logic       err_parity,
   output logic       err_frame,
   output logic       err_overrun,
   output logic       irq
);

   localparam int MIN_BITS = 5;
   localparam int MAX_BITS = 8;

   logic                line_s;
   logic                done;
   logic [MAX_BITS-1:0] char_w;
   logic                perr_w;
   logic                ferr_w;

   srx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (rx_serial),
      .q_sync  (line_s)
   );

   srx_frame #(.OVS_RATE(OVS_RATE), .MIN_BITS(MIN_BITS), .MAX_BITS(MAX_BITS)) u_frame (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick         (tick16),
      .line         (line_s),
      .cfg_len      (cfg_len),
      .cfg_par_en   (cfg_par_en),
      .cfg_par_kind (cfg_par_kind),
      .cfg_two_stop (cfg_two_stop),
      .done_o       (done),
      .char_o       (char_w),
      .perr_o       (perr_w),
      .ferr_o       (ferr_w)
   );

   srx_hold #(.MAX_BITS(MAX_BITS)) u_hold (
      .clk         (clk),
      .rst_n       (rst_n),
      .done_i      (done),
      .char_i      (char_w),
      .perr_i      (perr_w),
      .ferr_i      (ferr_w),
      .rd_data     (rd_data),
      .rd_status   (rd_status),
      .cfg_irq_en  (cfg_irq_en),
      .rx_char     (rx_char),
      .data_ready  (data_ready),
      .err_parity  (err_parity),
      .err_frame   (err_frame),
      .err_overrun (err_overrun),
      .irq         (irq)
   );

   assert_ready_from_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(data_ready) |-> $past(done));

   assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (data_ready && cfg_irq_en));

endmodule

// File: tb/serial_char_receiver_tb.sv
`timescale 1ns/1ps
module serial_char_receiver_tb;

   localparam int TICKDIV = 4;
   localparam int BITCLK  = 16 * TICKDIV;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick16 = 1'b0;
   logic       rx_serial = 1'b1;
   logic [1:0] cfg_len = 2'd3;
   logic       cfg_par_en = 1'b0;
   logic [1:0] cfg_par_kind = 2'd0;
   logic       cfg_two_stop = 1'b0;
   logic       cfg_irq_en = 1'b0;
   logic       rd_data = 1'b0;
   logic       rd_status = 1'b0;
   logic [7:0] rx_char;
   logic       data_ready, err_parity, err_frame, err_overrun, irq;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   serial_char_receiver u_dut (
      .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_serial(rx_serial),
      .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_kind(cfg_par_kind),
      .cfg_two_stop(cfg_two_stop), .cfg_irq_en(cfg_irq_en),
      .rd_data(rd_data), .rd_status(rd_status), .rx_char(rx_char),
      .data_ready(data_ready), .err_parity(err_parity), .err_frame(err_frame),
      .err_overrun(err_overrun), .irq(irq)
   );

   initial begin
      int c = 0;
      forever begin
         @(negedge clk);
         tick16 = (c == TICKDIV - 1);
         c = (c == TICKDIV - 1) ? 0 : c + 1;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic bit_time(input logic v);
      rx_serial = v;
      repeat (BITCLK) @(negedge clk);
   endtask

   function automatic logic exp_par(input logic [7:0] d, input int nb, input logic [1:0] k);
      logic odd = 1'b0;
      for (int i = 0; i < nb; i++) odd ^= d[i];
      case (k)
         2'd0: return odd;
         2'd1: return ~odd;
         2'd2: return 1'b0;
         default: return 1'b1;
      endcase
   endfunction

   task automatic send(input logic [7:0] d, input logic bad_par, input logic bad_stop);
      int nb = 5 + int'(cfg_len);
      bit_time(1'b0);
      for (int i = 0; i < nb; i++) bit_time(d[i]);
      if (cfg_par_en) bit_time(exp_par(d, nb, cfg_par_kind) ^ bad_par);
      bit_time(~bad_stop);
      if (cfg_two_stop) bit_time(1'b1);
      rx_serial = 1'b1;
      repeat (16) @(negedge clk);
   endtask

   task automatic pulse_rd(input bit dat, input bit st);
      rd_data = dat;
      rd_status = st;
      @(negedge clk);
      rd_data = 1'b0;
      rd_status = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] pats [3];
      pats[0] = 8'hA5; pats[1] = 8'h3C; pats[2] = 8'hFF;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      // reset state
      chk("R3 reset data_ready", data_ready, 0);
      chk("R7 reset errors", {err_parity, err_frame, err_overrun}, 0);
      chk("R8 reset irq", irq, 0);

      // sweep over length, parity mode and stop count (R1, R6, R9)
      for (int l = 0; l < 4; l++) begin
         for (int pm = 0; pm < 5; pm++) begin
            for (int ts = 0; ts < 2; ts++) begin
               for (int p = 0; p < 3; p++) begin
                  logic [7:0] d = pats[p] ^ 8'(l * 37 + pm * 11 + ts * 5);
                  logic [7:0] m = 8'((1 << (5 + l)) - 1);
                  cfg_len = 2'(l);
                  cfg_par_en = (pm != 0);
                  cfg_par_kind = 2'((pm == 0) ? 0 : pm - 1);
                  cfg_two_stop = ts[0];
                  send(d, 1'b0, 1'b0);
                  chk("R1 char value", rx_char, d & m);
                  chk("R3 ready after frame", data_ready, 1);
                  chk("R6 no parity error", err_parity, 0);
                  chk("R9 R4 no framing error", err_frame, 0);
                  chk("R5 no overrun", err_overrun, 0);
                  pulse_rd(1'b1, 1'b1);
                  chk("R3 read clears ready", data_ready, 0);
               end
            end
         end
      end

      // parity corruption for each kind (R6), then status read clears (R7)
      cfg_len = 2'd3; cfg_par_en = 1'b1; cfg_two_stop = 1'b0;
      for (int k = 0; k < 4; k++) begin
         cfg_par_kind = 2'(k);
         send(8'h5A ^ 8'(k), 1'b1, 1'b0);
         chk("R6 parity error flagged", err_parity, 1);
         chk("R6 char still stored", rx_char, 8'h5A ^ 8'(k));
         pulse_rd(1'b1, 1'b0);
         chk("R7 data read keeps error", err_parity, 1);
         pulse_rd(1'b0, 1'b1);
         chk("R7 status read clears parity", err_parity, 0);
      end

      // framing error, one and two stop bits (R4, R9)
      cfg_par_en = 1'b0;
      for (int ts = 0; ts < 2; ts++) begin
         cfg_two_stop = ts[0];
         send(8'hC3, 1'b0, 1'b1);
         chk("R4 framing error", err_frame, 1);
         chk("R4 char value", rx_char, 8'hC3);
         pulse_rd(1'b1, 1'b1);
         chk("R7 framing cleared", err_frame, 0);
      end
      // bad second stop bit only
      cfg_two_stop = 1'b1;
      rx_serial = 1'b0; repeat (BITCLK) @(negedge clk);
      for (int i = 0; i < 8; i++) bit_time(i[0]);
      bit_time(1'b1);
      bit_time(1'b0);
      rx_serial = 1'b1; repeat (16) @(negedge clk);
      chk("R9 second stop checked", err_frame, 1);
      pulse_rd(1'b1, 1'b1);
      cfg_two_stop = 1'b0;

      // overrun (R5)
      send(8'h11, 1'b0, 1'b0);
      send(8'h22, 1'b0, 1'b0);
      chk("R5 overrun flagged", err_overrun, 1);
      chk("R5 newer char kept", rx_char, 8'h22);
      pulse_rd(1'b1, 1'b0);
      chk("R5 overrun sticky after data read", err_overrun, 1);
      pulse_rd(1'b0, 1'b1);
      chk("R7 overrun cleared", err_overrun, 0);

      // false start (R2)
      rx_serial = 1'b0;
      repeat (2 * TICKDIV) @(negedge clk);
      rx_serial = 1'b1;
      repeat (3 * BITCLK) @(negedge clk);
      chk("R2 glitch gives no char", data_ready, 0);
      send(8'h96, 1'b0, 1'b0);
      chk("R2 next frame ok", rx_char, 8'h96);
      chk("R2 next frame clean", {err_parity, err_frame, err_overrun}, 0);
      pulse_rd(1'b1, 1'b0);

      // interrupt (R8)
      cfg_irq_en = 1'b0;
      send(8'h0F, 1'b0, 1'b0);
      chk("R8 irq off when disabled", irq, 0);
      cfg_irq_en = 1'b1;
      @(negedge clk);
      chk("R8 irq on when enabled and ready", irq, 1);
      pulse_rd(1'b1, 1'b0);
      chk("R8 irq drops after read", irq, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule